// File: doc/BRIEF.md
# Condition Code Execute Gate

This unit decides whether an instruction should take effect. It looks at the four-bit condition field of the instruction and at the current negative (N), zero (Z), carry (C) and overflow (V) status flags, and it returns one execute-enable bit. When that bit is low, the stages after it must drop both the register write and the flag update for the instruction.

There are sixteen condition codes. They cover equality, the single flags, unsigned ordering and signed ordering, plus one code that always executes and one code that is reserved. The codes come in pairs: within each pair, the odd code is the logical complement of the even code. The reserved code never executes, and a separate output reports that it was seen, so that the surrounding logic can treat it as it sees fit.

The unit is purely combinational. It has no clock, no reset and no internal state, so the enable settles in the same cycle as the condition field and the flags that feed it.

Top module: `cond_exec_eval`

## Requirements
- R1: Code 0000 executes exactly when Z is 1, and code 0001 executes exactly when Z is 0.
- R2: Code 0010 executes exactly when C is 1, and code 0011 executes exactly when C is 0.
- R3: Code 0100 executes exactly when N is 1, and code 0101 executes exactly when N is 0.
- R4: Code 0110 executes exactly when V is 1, and code 0111 executes exactly when V is 0.
- R5: Code 1000 executes when C is 1 and Z is 0 (unsigned higher). Code 1001 executes when C is 0 or Z is 1 (unsigned lower or same).
- R6: Code 1010 executes when N equals V (signed greater or equal). Code 1011 executes when N differs from V (signed less).
- R7: Code 1100 executes when Z is 0 and N equals V (signed greater). Code 1101 executes when Z is 1 or N differs from V (signed less or equal).
- R8: Code 1110 executes for all sixteen flag combinations.
- R9: Code 1111 never executes and drives `cond_rsvd_o` high. `cond_rsvd_o` is low for every other code.
- R10: The outputs follow the inputs combinationally, with no clock, so a change at the inputs shows at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_i | input | 4 | Condition field of the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| exec_en_o | output | 1 | High when the instruction may write its results |
| cond_rsvd_o | output | 1 | High when the condition field holds the reserved code |

## Verification
The bench drives all sixteen codes against all sixteen flag combinations, which covers the following faults:
- Mixing up the signed and unsigned orderings would break the cases where C and N/V disagree.
- Dropping the Z term from the greater-than or less-or-equal codes would execute on equal operands.
- Inverting the wrong half of a complementary pair would flip every result for those codes.
- Treating the reserved code as a second always-execute code would raise the enable where it must stay low, or leave the reserved flag unset.
- A stray register on the path would make the output lag behind an input change made inside a single clock phase.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  localparam int COND_W  = 4;
  localparam int GROUP_W = COND_W - 1;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } status_flags_t;

  // Predicate groups: the low bit of the condition code selects polarity.
  typedef enum logic [GROUP_W-1:0] {
    GRP_ZERO     = 3'd0,
    GRP_CARRY    = 3'd1,
    GRP_NEG      = 3'd2,
    GRP_OVF      = 3'd3,
    GRP_U_HIGHER = 3'd4,
    GRP_S_GE     = 3'd5,
    GRP_S_GT     = 3'd6,
    GRP_ALWAYS   = 3'd7
  } pred_group_t;

endpackage

// File: rtl/cond_base_sel.sv
module cond_base_sel
  import cond_eval_pkg::*;
(
  input  pred_group_t   group_i,
  input  status_flags_t flags_i,
  output logic          pred_o
);

  logic signs_match;

  assign signs_match = ~(flags_i.n ^ flags_i.v);

  always_comb begin
    case (group_i)
      GRP_ZERO:     pred_o = flags_i.z;
      GRP_CARRY:    pred_o = flags_i.c;
      GRP_NEG:      pred_o = flags_i.n;
      GRP_OVF:      pred_o = flags_i.v;
      GRP_U_HIGHER: pred_o = flags_i.c & ~flags_i.z;
      GRP_S_GE:     pred_o = signs_match;
      GRP_S_GT:     pred_o = ~flags_i.z & signs_match;
      default:      pred_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cond_polarity.sv
module cond_polarity
  import cond_eval_pkg::*;
(
  input  pred_group_t group_i,
  input  logic        pred_i,
  input  logic        invert_i,
  output logic        exec_o,
  output logic        rsvd_o
);

  logic is_always_grp;

  assign is_always_grp = (group_i == GRP_ALWAYS);

  // The always group yields 1; inverting it gives the never/reserved case.
  assign exec_o = pred_i ^ invert_i;
  assign rsvd_o = is_always_grp & invert_i;

endmodule

// File: rtl/cond_exec_eval.sv
module cond_exec_eval
  import cond_eval_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_v_i,
  output logic              exec_en_o,
  output logic              cond_rsvd_o
);

  status_flags_t flags;
  pred_group_t   group;
  logic          invert;
  logic          pred;

  assign flags  = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
  assign group  = pred_group_t'(cond_i[COND_W-1:1]);
  assign invert = cond_i[0];

  cond_base_sel u_base (
    .group_i (group),
    .flags_i (flags),
    .pred_o  (pred)
  );

  cond_polarity u_pol (
    .group_i  (group),
    .pred_i   (pred),
    .invert_i (invert),
    .exec_o   (exec_en_o),
    .rsvd_o   (cond_rsvd_o)
  );

endmodule

// File: rtl/cond_exec_eval_chk.sv
module cond_exec_eval_chk
  import cond_eval_pkg::*;
(
  input logic [COND_W-1:0] cond_i,
  input logic              flag_n_i,
  input logic              flag_z_i,
  input logic              flag_c_i,
  input logic              flag_v_i,
  input logic              exec_en_o,
  input logic              cond_rsvd_o
);

  always_comb begin
    if (!$isunknown({cond_i, flag_n_i, flag_z_i, flag_c_i, flag_v_i})) begin
      if (cond_i == 4'b0000) assert_eq_R1: assert (exec_en_o == flag_z_i);
      if (cond_i == 4'b0011) assert_cc_R2: assert (exec_en_o != flag_c_i);
      if (cond_i == 4'b0100) assert_mi_R3: assert (exec_en_o == flag_n_i);
      if (cond_i == 4'b0111) assert_vc_R4: assert (exec_en_o != flag_v_i);
      if (cond_i == 4'b1001 && flag_z_i) assert_ls_R5: assert (exec_en_o);
      if (cond_i == 4'b1011) assert_lt_R6: assert (exec_en_o == (flag_n_i != flag_v_i));
      if (cond_i == 4'b1100 && flag_z_i) assert_gt_R7: assert (!exec_en_o);
      if (cond_i == 4'b1110) assert_al_R8: assert (exec_en_o);
      assert_rsvd_R9: assert (cond_rsvd_o == (cond_i == 4'b1111));
      if (cond_rsvd_o) assert_rsvd_noexec_R9: assert (!exec_en_o);
    end
  end

endmodule

bind cond_exec_eval cond_exec_eval_chk u_chk (.*);

// File: tb/tb_cond_exec_eval.sv
`timescale 1ns/1ps
module tb_cond_exec_eval;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond_i = 4'd0;
  logic       flag_n_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0, flag_v_i = 1'b0;
  logic       exec_en_o, cond_rsvd_o;

  int  applied = 0;
  int  miscompares = 0;
  bit  reported = 1'b0;

  always #2 clk = ~clk;

  cond_exec_eval dut (
    .cond_i      (cond_i),
    .flag_n_i    (flag_n_i),
    .flag_z_i    (flag_z_i),
    .flag_c_i    (flag_c_i),
    .flag_v_i    (flag_v_i),
    .exec_en_o   (exec_en_o),
    .cond_rsvd_o (cond_rsvd_o)
  );

  function automatic bit model_exec(input logic [3:0] c, input bit n, input bit z,
                                    input bit cy, input bit v);
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5:   return "R3";
      4'd6, 4'd7:   return "R4";
      4'd8, 4'd9:   return "R5";
      4'd10, 4'd11: return "R6";
      4'd12, 4'd13: return "R7";
      4'd14:        return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s cond=%b nzcv=%b%b%b%b actual=%b expected=%b",
               req, what, cond_i, flag_n_i, flag_z_i, flag_c_i, flag_v_i, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(4 * 5000);
    applied++;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // State after reset with all inputs zero: EQ with Z clear does not execute.
    check("R1", "exec after reset", exec_en_o, 1'b0);
    check("R9", "rsvd after reset", cond_rsvd_o, 1'b0);

    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        cond_i = 4'(c);
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = 4'(f);
        #1;
        check(req_of(4'(c)), "exec", exec_en_o,
              model_exec(4'(c), flag_n_i, flag_z_i, flag_c_i, flag_v_i));
        check("R9", "rsvd", cond_rsvd_o, (c == 15) ? 1'b1 : 1'b0);
      end
    end

    // R10: two input changes inside one low phase, no clock edge between them.
    @(negedge clk);
    cond_i = 4'b1110;
    {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = 4'b0000;
    #0.5;
    check("R10", "exec same-phase AL", exec_en_o, 1'b1);
    cond_i = 4'b1111;
    #0.5;
    check("R10", "exec same-phase reserved", exec_en_o, 1'b0);
    check("R10", "rsvd same-phase reserved", cond_rsvd_o, 1'b1);
    cond_i = 4'b0000;
    flag_z_i = 1'b1;
    #0.5;
    check("R10", "exec same-phase EQ", exec_en_o, 1'b1);

    finish_run();
  end

endmodule